// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Controller

This block is the host-side master for a string of identical 18-bit converters connected in series: every converter's serial output drives the serial input of its downstream neighbour, the input of the converter farthest from the host is tied low, and the output of the converter nearest the host returns to this controller. On a start request the controller places a strap level on the serial clock, raises the shared convert line, waits for the conversion to end and then clocks the whole chain out. The assembled words are written into a small result buffer.

Two readback variants are supported and chosen per transaction through `busy_sel`. With the clock strapped low, the conversion wait is a fixed number of system cycles and exactly 18×N falling clock edges follow. With the clock strapped high, the controller waits until the returning data line goes high, which means every converter has finished. It then issues 18×N+1 falling edges and discards the first sampled bit, since that bit is only the busy marker.

The serial clock is derived from the system clock. Each pulse is `SCK_HALF` cycles high followed by `SCK_HALF` cycles low. The returning line is sampled once per pulse, just before the pulse's rising half, so the data has had `SCK_HALF` cycles to settle since the previous falling edge.

Top module: `chainrd_ctrl`

## Requirements
- R1: When a start is accepted, `sck` is driven to the strap level (0 when `busy_sel` is 0, 1 when it is 1) for `STRAP_CYC` cycles before `cnv` rises, and it keeps that level across the `cnv` rising edge.
- R2: `cnv` stays high from its rising edge through the last falling `sck` edge. It goes low in the same cycle that `done` is high, and at no other time.
- R3: With the low strap, `sck` stays low for the whole conversion wait and first rises exactly `CONV_CYC`+1 cycles after `cnv` rises. Exactly 18×N falling edges of `sck` occur in the transaction.
- R4: With the high strap, `sck` stays high while `sdo_in` is low after `cnv` rises, however long that lasts. Readback starts only once `sdo_in` is seen high, and exactly 18×N+1 falling edges occur in the transaction.
- R5: Bits are taken MSB first. With the high strap, the first sampled bit (the busy marker) is not stored.
- R6: The word from chain position k (k = 0 is the converter nearest the host, read first) is stored at buffer index N−1−k. Buffer index j appears on `result_flat[18·j+17 : 18·j]`, so index 0 holds the farthest converter.
- R7: `done` is a single-cycle pulse. All N words are valid on `result_flat` in that cycle, and `sck` is low.
- R8: A start request while a transaction is in progress (strap, conversion or readback) produces a one-cycle `overrun` pulse in the following cycle. It is otherwise ignored: the running transaction completes with correct data and no new conversion follows. A start accepted while idle gives no `overrun`.
- R9: During reset, `cnv`, `sck`, `done` and `overrun` are low and `result_flat` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion and readback |
| busy_sel | input | 1 | Per-transaction strap: 0 fixed wait, 1 busy marker |
| sdo_in | input | 1 | Serial data returned by the converter nearest the host |
| cnv | output | 1 | Shared convert line |
| sck | output | 1 | Serial clock to all converters |
| result_flat | output | NUM_DEV*18 | Result buffer, entry j in bits [18j+17:18j] |
| done | output | 1 | One-cycle pulse when all results are stored |
| overrun | output | 1 | One-cycle pulse for a rejected start |

## Verification
A wrong pulse or bit counter shows up as a falling-edge count off by one at the `cnv` falling edge, or as every word shifted by one bit position. A wrong busy-bit discard shifts all words by one bit. A wrong index mapping shows up when the `done` pulse arrives, as words swapped between buffer entries. A bad strap or conversion wait is visible at the `cnv` rising edge itself, or when the first `sck` rise comes earlier or later than `CONV_CYC`+1 cycles. A faulty rejection of a start request shows up one cycle later as a missing `overrun`, or as a second conversion after `done`.

// File: rtl/chainrd_pkg.sv
package chainrd_pkg;
    localparam int SAMPLE_W = 18;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STRAP = 2'd1,
        ST_CONV  = 2'd2,
        ST_SHIFT = 2'd3
    } chain_state_e;
endpackage

// File: rtl/chainrd_pulse_gen.sv
module chainrd_pulse_gen #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pulse_first,
    output logic pulse_last,
    output logic phase_high
);
    localparam int PERIOD = 2 * SCK_HALF;
    localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = '0;
        if (run) begin
            if (ph_q == PH_W'(PERIOD - 1)) begin
                ph_d = '0;
            end else begin
                ph_d = ph_q + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign pulse_first = run && (ph_q == '0);
    assign pulse_last  = run && (ph_q == PH_W'(PERIOD - 1));
    assign phase_high  = (ph_q < PH_W'(SCK_HALF));
endmodule

// File: rtl/chainrd_word_asm.sv
module chainrd_word_asm #(
    parameter int WORD_W  = 18,
    parameter int NUM_DEV = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     sample_en,
    input  logic                     bit_in,
    output logic                     wr_en,
    output logic [((NUM_DEV > 1) ? $clog2(NUM_DEV) : 1)-1:0] wr_idx,
    output logic [WORD_W-1:0]        wr_word
);
    localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int BC_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [BC_W-1:0]   bcnt;
        logic [IDX_W-1:0]  widx;
    } asm_regs_t;

    asm_regs_t d, q;
    logic      word_end;

    assign word_end = sample_en && (q.bcnt == BC_W'(WORD_W - 1));

    always_comb begin
        d = q;
        if (clear) begin
            d.word = '0;
            d.bcnt = '0;
            d.widx = '0;
        end else if (sample_en) begin
            d.word = {q.word[WORD_W-2:0], bit_in};
            if (word_end) begin
                d.bcnt = '0;
                d.widx = q.widx + IDX_W'(1);
            end else begin
                d.bcnt = q.bcnt + BC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en   = word_end;
    assign wr_word = {q.word[WORD_W-2:0], bit_in};
    assign wr_idx  = IDX_W'(NUM_DEV - 1) - q.widx;
endmodule

// File: rtl/chainrd_result_buf.sv
module chainrd_result_buf #(
    parameter int WORD_W  = 18,
    parameter int NUM_DEV = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [((NUM_DEV > 1) ? $clog2(NUM_DEV) : 1)-1:0] wr_idx,
    input  logic [WORD_W-1:0]            wr_word,
    output logic [NUM_DEV*WORD_W-1:0]    result_flat
);
    localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    for (genvar j = 0; j < NUM_DEV; j++) begin : g_entry
        logic [WORD_W-1:0] entry_d, entry_q;

        always_comb begin
            entry_d = entry_q;
            if (wr_en && (wr_idx == IDX_W'(j))) begin
                entry_d = wr_word;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else begin
                entry_q <= entry_d;
            end
        end

        assign result_flat[j*WORD_W +: WORD_W] = entry_q;
    end
endmodule

// File: rtl/chainrd_ctrl.sv
module chainrd_ctrl
    import chainrd_pkg::*;
#(
    parameter int NUM_DEV   = 3,
    parameter int SCK_HALF  = 2,
    parameter int STRAP_CYC = 2,
    parameter int CONV_CYC  = 75
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          busy_sel,
    input  logic                          sdo_in,
    output logic                          cnv,
    output logic                          sck,
    output logic [NUM_DEV*SAMPLE_W-1:0]   result_flat,
    output logic                          done,
    output logic                          overrun
);
    localparam int TOT_BITS = NUM_DEV * SAMPLE_W;
    localparam int BIT_W    = $clog2(TOT_BITS + 2);
    localparam int CNT_MAX  = (CONV_CYC > STRAP_CYC) ? CONV_CYC : STRAP_CYC;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int IDX_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    typedef struct packed {
        chain_state_e     state;
        logic             mode;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bits;
        logic             cnv;
        logic             sck;
        logic             done;
        logic             ovr;
    } ctrl_regs_t;

    ctrl_regs_t d, q;

    logic             pulse_first, pulse_last, phase_high;
    logic             run_shift, accept, sample_en;
    logic [BIT_W-1:0] last_bit;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [SAMPLE_W-1:0] wr_word;
    logic             in_idle, in_conv;

    assign run_shift = (q.state == ST_SHIFT);
    assign accept    = (q.state == ST_IDLE) && start;
    assign last_bit  = q.mode ? BIT_W'(TOT_BITS) : BIT_W'(TOT_BITS - 1);
    // the very first sample under the high strap is the busy marker
    assign sample_en = pulse_first && !(q.mode && (q.bits == '0));
    assign in_idle   = (q.state == ST_IDLE);
    assign in_conv   = (q.state == ST_CONV);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.ovr  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                d.cnv = 1'b0;
                d.sck = 1'b0;
                if (start) begin
                    d.state = ST_STRAP;
                    d.mode  = busy_sel;
                    d.sck   = busy_sel;
                    d.cnt   = CNT_W'(STRAP_CYC - 1);
                end
            end
            ST_STRAP: begin
                d.ovr = start;
                if (q.cnt == '0) begin
                    d.state = ST_CONV;
                    d.cnv   = 1'b1;
                    d.cnt   = CNT_W'(CONV_CYC - 1);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_CONV: begin
                d.ovr = start;
                if (q.mode) begin
                    if (sdo_in) begin
                        d.state = ST_SHIFT;
                        d.bits  = '0;
                    end
                end else if (q.cnt == '0) begin
                    d.state = ST_SHIFT;
                    d.bits  = '0;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_SHIFT: begin
                d.ovr = start;
                d.sck = phase_high;
                if (pulse_last) begin
                    if (q.bits == last_bit) begin
                        d.state = ST_IDLE;
                        d.cnv   = 1'b0;
                        d.done  = 1'b1;
                    end else begin
                        d.bits = q.bits + BIT_W'(1);
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, mode: 1'b0, cnt: '0, bits: '0,
                   cnv: 1'b0, sck: 1'b0, done: 1'b0, ovr: 1'b0};
        end else begin
            q <= d;
        end
    end

    chainrd_pulse_gen #(.SCK_HALF(SCK_HALF)) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_shift),
        .pulse_first (pulse_first),
        .pulse_last  (pulse_last),
        .phase_high  (phase_high)
    );

    chainrd_word_asm #(.WORD_W(SAMPLE_W), .NUM_DEV(NUM_DEV)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample_en (sample_en),
        .bit_in    (sdo_in),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_word   (wr_word)
    );

    chainrd_result_buf #(.WORD_W(SAMPLE_W), .NUM_DEV(NUM_DEV)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_word     (wr_word),
        .result_flat (result_flat)
    );

    assign cnv     = q.cnv;
    assign sck     = q.sck;
    assign done    = q.done;
    assign overrun = q.ovr;
endmodule

// File: rtl/chainrd_ctrl_chk.sv
module chainrd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic cnv,
    input logic sck,
    input logic done,
    input logic overrun,
    input logic mode,
    input logic in_idle,
    input logic in_conv
);
    // R1: strap level present and steady across the convert edge
    p_strap_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> (sck == mode) && $stable(sck));

    // R2: convert only drops when the transaction completes
    p_cnv_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv) |-> done);

    // R4: no clock activity while a conversion is pending
    p_sck_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_conv && $past(in_conv)) |-> $stable(sck));

    // R7: completion is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: overrun only follows a start made while busy
    p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(start) && !$past(in_idle)));

    // R7: serial clock is low when the transaction ends
    p_done_sck_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sck);
endmodule

bind chainrd_ctrl chainrd_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cnv     (cnv),
    .sck     (sck),
    .done    (done),
    .overrun (overrun),
    .mode    (q.mode),
    .in_idle (in_idle),
    .in_conv (in_conv)
);

// File: tb/chainrd_ctrl_test.sv
module chainrd_ctrl_test;
    localparam int N      = 3;
    localparam int W      = 18;
    localparam int CH_W   = N * W;
    localparam int CONV   = 75;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy_sel = 1'b0;
    logic sdo_in;
    logic cnv, sck, done, overrun;
    logic [CH_W-1:0] result_flat;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    chainrd_ctrl #(.NUM_DEV(N), .SCK_HALF(2), .STRAP_CYC(2), .CONV_CYC(CONV)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .busy_sel    (busy_sel),
        .sdo_in      (sdo_in),
        .cnv         (cnv),
        .sck         (sck),
        .result_flat (result_flat),
        .done        (done),
        .overrun     (overrun)
    );

    // behavioural chain of converters
    logic [CH_W:0]   chain = '0;
    logic [CH_W-1:0] dev_word = '0;
    int  conv_dly = 60;
    int  falls = 0;
    int  cyc = 0;
    int  cnv_cyc = 0;
    int  rise_cyc = 0;
    bit  rise_seen = 1'b0;
    logic strap_seen = 1'b0;

    assign sdo_in = chain[CH_W];

    always @(negedge clk) cyc++;

    always begin
        logic bm;
        @(posedge cnv);
        strap_seen = sck;
        bm         = sck;
        falls      = 0;
        rise_seen  = 1'b0;
        cnv_cyc    = cyc;
        chain      = '0;
        repeat (conv_dly) @(posedge clk);
        #1;
        chain = bm ? {1'b1, dev_word} : {dev_word, 1'b0};
    end

    always @(negedge sck) begin
        falls++;
        chain = {chain[CH_W-1:0], 1'b0};
    end

    always @(posedge sck) begin
        if (!rise_seen) begin
            rise_cyc  = cyc;
            rise_seen = 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!done && g < 5000);
    endtask

    task automatic check_words(input logic [CH_W-1:0] w, input string nm);
        // R6: index 2 = nearest (w top), index 0 = farthest
        chk({nm, " R6 idx2"}, 64'(result_flat[2*W +: W]), 64'(w[2*W +: W]));
        chk({nm, " R6 idx1"}, 64'(result_flat[W +: W]),   64'(w[W +: W]));
        chk({nm, " R6 idx0 R5"}, 64'(result_flat[0 +: W]), 64'(w[0 +: W]));
    endtask

    task automatic do_run(input logic m, input logic [CH_W-1:0] w, input int dly, input string nm);
        dev_word = w;
        conv_dly = dly;
        @(negedge clk);
        start    = 1'b1;
        busy_sel = m;
        @(negedge clk);
        start = 1'b0;
        chk({nm, " R8 no overrun on idle start"}, 64'(overrun), 64'd0);
        wait_done();
        chk({nm, " R7 done"}, 64'(done), 64'd1);
        chk({nm, " R2 cnv low at done"}, 64'(cnv), 64'd0);
        chk({nm, " R7 sck low at done"}, 64'(sck), 64'd0);
        chk({nm, " R1 strap"}, 64'(strap_seen), 64'(m));
        if (m) chk({nm, " R4 falls"}, 64'(falls), 64'(CH_W + 1));
        else   chk({nm, " R3 falls"}, 64'(falls), 64'(CH_W));
        if (!m) chk({nm, " R3 first rise gap"}, 64'(rise_cyc - cnv_cyc), 64'(CONV + 1));
        check_words(w, nm);
        @(negedge clk);
        chk({nm, " R7 done single"}, 64'(done), 64'd0);
    endtask

    // {busy, nearest, middle, farthest}
    localparam logic [CH_W:0] VEC [0:4] = '{
        {1'b0, 18'h3FFFF, 18'h00000, 18'h20000},
        {1'b1, 18'h12345, 18'h2AAAA, 18'h15555},
        {1'b0, 18'h00001, 18'h3FFFE, 18'h1F0F0},
        {1'b1, 18'h20000, 18'h3FFFF, 18'h00001},
        {1'b1, 18'h0ABCD, 18'h31234, 18'h0FFFF}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 cnv", 64'(cnv), 64'd0);
        chk("R9 sck", 64'(sck), 64'd0);
        chk("R9 done", 64'(done), 64'd0);
        chk("R9 overrun", 64'(overrun), 64'd0);
        chk("R9 results", 64'(result_flat), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 5; i++) begin
            logic m;
            int   dly;
            m   = VEC[i][CH_W];
            dly = m ? ((i == 4) ? 300 : 50) : 60;
            // vector 4 holds the chain busy for a long time (R4)
            do_run(m, VEC[i][CH_W-1:0], dly, $sformatf("vec%0d", i));
            repeat (5) @(negedge clk);
        end

        // R8: starts during conversion and during readback are rejected
        begin
            logic [CH_W-1:0] w;
            int extra;
            w = {18'h11111, 18'h22222, 18'h33333};
            dev_word = w;
            conv_dly = 60;
            @(negedge clk);
            start = 1'b1;
            busy_sel = 1'b0;
            @(negedge clk);
            start = 1'b0;
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R8 overrun during conversion", 64'(overrun), 64'd1);
            @(negedge clk);
            chk("R8 overrun single", 64'(overrun), 64'd0);
            repeat (90) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R8 overrun during readback", 64'(overrun), 64'd1);
            wait_done();
            chk("R8 run completes", 64'(done), 64'd1);
            chk("R8 falls unchanged", 64'(falls), 64'(CH_W));
            check_words(w, "R8");
            extra = 0;
            for (int k = 0; k < 120; k++) begin
                @(negedge clk);
                if (cnv) extra++;
            end
            chk("R8 no extra conversion", 64'(extra), 64'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule